// File: doc/BRIEF.md
# GPIO Interrupt Source Mapper

This block turns a wide vector of GPIO interrupt lines into 32 independent interrupt channels for a parent interrupt controller. Each channel has a programmable selector that picks one GPIO line, an enable bit and a two-bit trigger mode: rising edge, falling edge, high level or low level. The chosen line is brought into the clock domain through a two-flop synchronizer. A detected event latches a per-channel status bit. While that bit is set, the channel drives an active-high request to the parent.

Software reaches the block through a simple 32-bit register port: a write strobe with address and data, and a combinational read data bus. An interrupt handler clears a status bit by writing the status word back with that bit at zero. If a selector changes, the edge history of that channel is reloaded from the new line, so switching lines never produces a false event.

Top module: `gpio_irq_mapper`

## Requirements
- R1: After reset, every register reads 0 and `irq_req` is all zero.
- R2: The configuration byte of channel c is in the word at address 0x30 + 4*(c/4), bits [8*(c%4)+7 : 8*(c%4)]. Bit 7 of the byte is the enable and bits [6:0] are the GPIO line number. A written value reads back unchanged.
- R3: Channels 0 to 15 have their trigger modes in the word at 0x24, and channels 16 to 31 in the word at 0x28. Local index k uses bits [2k+1:2k]. A write to one of these words leaves the other unchanged.
- R4: Trigger code 0 detects a rising edge and code 1 a falling edge. The status bit and the request go to 1 on the third rising clock edge that samples the new line value.
- R5: Trigger code 2 (high) and code 3 (low) set the status bit on every cycle in which the level holds. Once the level is gone, the bit can be cleared.
- R6: The status word is at 0x20, and bit c belongs to channel c. Writing 0 to a set bit clears it. Writing 1 never sets a bit. `irq_req[c]` is 1 exactly when status bit c is 1.
- R7: If a detection and a software clear hit the same status bit in one cycle, the bit stays 1.
- R8: A channel whose enable bit is 0 never sets its status bit or its request.
- R9: A line number at or above `NUM_SRC` selects a constant 0. A low-level trigger on such a channel fires, and an edge trigger never does.
- R10: Writing a new line number to a channel causes no event from the step between the old line and the new one. Detection resumes on the new line afterwards.
- R11: Addresses other than 0x20, 0x24, 0x28 and 0x30 to 0x4C read 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| gpio_src | input | NUM_SRC | GPIO interrupt lines, asynchronous |
| irq_req | output | 32 | Level-high request per channel to the parent |

## Verification
A wrong synchronizer depth or a wrong detection term makes a request rise one cycle early or late. It can also make the request rise on the wrong edge polarity. The cycle-by-cycle comparison of `irq_req` catches this on the first affected edge. Wrong blanking after a line change shows as a request about three cycles after the selector write. A lost set-over-clear priority shows as a level channel whose request drops for one cycle after a status write. A byte or field decoded at the wrong position shows at once on readback and, a few cycles later, as a request on the wrong channel.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int CH_COUNT       = 32;
    localparam int DATA_W         = 32;
    localparam int ADDR_W         = 8;
    localparam int SEL_W          = 7;
    localparam int CFG_W          = SEL_W + 1;
    localparam int TRIG_W         = 2;
    localparam int CH_PER_WORD    = DATA_W / CFG_W;
    localparam int TRIG_PER_WORD  = DATA_W / TRIG_W;
    localparam int SEL_WORDS      = CH_COUNT / CH_PER_WORD;
    localparam int TRIG_WORDS     = CH_COUNT / TRIG_PER_WORD;
    localparam int SRC_SPACE      = 1 << SEL_W;
    localparam int BLANK_W        = 2;
    localparam logic [BLANK_W-1:0] BLANK_LOAD = 2'd3;

    localparam logic [ADDR_W-1:0] ADDR_STATUS  = 8'h20;
    localparam logic [ADDR_W-1:0] ADDR_TRIG_LO = 8'h24;
    localparam logic [ADDR_W-1:0] ADDR_TRIG_HI = 8'h28;
    localparam logic [ADDR_W-1:0] ADDR_SEL0    = 8'h30;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_RISE = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_HIGH = 2'd2,
        TRIG_LOW  = 2'd3
    } trig_e;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] src;
    } chan_cfg_t;

    function automatic logic [ADDR_W-1:0] sel_addr(input int w);
        return ADDR_W'(int'(ADDR_SEL0) + 4 * w);
    endfunction

    function automatic logic [ADDR_W-1:0] trig_addr(input int t);
        return (t == 0) ? ADDR_TRIG_LO : ADDR_TRIG_HI;
    endfunction

    function automatic logic trig_hit(input trig_e mode, input logic cur, input logic prev);
        logic r;
        case (mode)
            TRIG_RISE: r = cur & ~prev;
            TRIG_FALL: r = ~cur & prev;
            TRIG_HIGH: r = cur;
            default:   r = ~cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mapper_channel.sv
module mapper_channel
    import mapper_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_SPACE-1:0] src_pad,
    input  chan_cfg_t            cfg,
    input  logic [TRIG_W-1:0]    trig,
    input  logic                 resel,
    output logic                 hit
);

    logic               raw;
    logic               sync1_q;
    logic               sync2_q;
    logic               hist_q;
    logic [BLANK_W-1:0] blank_q;

    // Line picked by the selector; unimplemented numbers see the zero pad
    assign raw = src_pad[cfg.src];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            hist_q  <= 1'b0;
            blank_q <= '0;
        end else begin
            sync1_q <= raw;
            sync2_q <= sync1_q;
            hist_q  <= sync2_q;
            if (resel)
                blank_q <= BLANK_LOAD;
            else if (blank_q != '0)
                blank_q <= BLANK_W'(blank_q - 1'b1);
        end
    end

    // Blanking covers the cycles in which the pipeline still mixes lines
    assign hit = cfg.en && (blank_q == '0) && trig_hit(trig_e'(trig), sync2_q, hist_q);

endmodule

// File: rtl/mapper_regs.sv
module mapper_regs
    import mapper_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic                              bus_wr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    input  logic [CH_COUNT-1:0]               set_vec,
    output chan_cfg_t [CH_COUNT-1:0]          cfg_o,
    output logic [CH_COUNT-1:0][TRIG_W-1:0]   trig_o,
    output logic [CH_COUNT-1:0]               resel_o,
    output logic [CH_COUNT-1:0]               status_o
);

    chan_cfg_t            cfg_q  [CH_COUNT];
    logic [TRIG_W-1:0]    trig_q [CH_COUNT];
    logic [CH_COUNT-1:0]  status_q;
    logic                 status_we;

    for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
        localparam int W = c / CH_PER_WORD;
        localparam int B = c % CH_PER_WORD;
        localparam int T = c / TRIG_PER_WORD;
        localparam int K = c % TRIG_PER_WORD;

        logic      sel_we;
        logic      trig_we;
        chan_cfg_t cfg_new;

        assign sel_we  = bus_wr && (bus_addr == sel_addr(W));
        assign trig_we = bus_wr && (bus_addr == trig_addr(T));
        assign cfg_new = chan_cfg_t'(bus_wdata[CFG_W*B +: CFG_W]);
        assign resel_o[c] = sel_we && (cfg_new.src != cfg_q[c].src);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[c]  <= '0;
                trig_q[c] <= '0;
            end else begin
                if (sel_we)
                    cfg_q[c] <= cfg_new;
                if (trig_we)
                    trig_q[c] <= bus_wdata[TRIG_W*K +: TRIG_W];
            end
        end

        assign cfg_o[c]  = cfg_q[c];
        assign trig_o[c] = trig_q[c];
    end

    assign status_we = bus_wr && (bus_addr == ADDR_STATUS);

    // A detection in the same cycle overrides the software clear
    always_ff @(posedge clk) begin
        if (rst)
            status_q <= '0;
        else
            status_q <= (status_we ? (status_q & bus_wdata) : status_q) | set_vec;
    end

    assign status_o = status_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_STATUS)
            bus_rdata = status_q;
        for (int t = 0; t < TRIG_WORDS; t++) begin
            if (bus_addr == trig_addr(t)) begin
                for (int k = 0; k < TRIG_PER_WORD; k++)
                    bus_rdata[TRIG_W*k +: TRIG_W] = trig_q[t*TRIG_PER_WORD + k];
            end
        end
        for (int w = 0; w < SEL_WORDS; w++) begin
            if (bus_addr == sel_addr(w)) begin
                for (int b = 0; b < CH_PER_WORD; b++)
                    bus_rdata[CFG_W*b +: CFG_W] = cfg_q[w*CH_PER_WORD + b];
            end
        end
    end

endmodule

// File: rtl/gpio_irq_mapper.sv
module gpio_irq_mapper
    import mapper_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0]  gpio_src,
    output logic [CH_COUNT-1:0] irq_req
);

    logic [SRC_SPACE-1:0]            src_pad;
    chan_cfg_t [CH_COUNT-1:0]        cfg;
    logic [CH_COUNT-1:0][TRIG_W-1:0] trig;
    logic [CH_COUNT-1:0]             resel;
    logic [CH_COUNT-1:0]             set_vec;
    logic [CH_COUNT-1:0]             status;
    logic [CH_COUNT-1:0]             en_vec;
    logic [CH_COUNT*TRIG_W-1:0]      trig_vec;

    if (NUM_SRC < SRC_SPACE) begin : g_pad
        assign src_pad = {{(SRC_SPACE - NUM_SRC){1'b0}}, gpio_src};
    end else begin : g_full
        assign src_pad = gpio_src[SRC_SPACE-1:0];
    end

    mapper_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .set_vec   (set_vec),
        .cfg_o     (cfg),
        .trig_o    (trig),
        .resel_o   (resel),
        .status_o  (status)
    );

    for (genvar c = 0; c < CH_COUNT; c++) begin : g_chan
        mapper_channel chan_i (
            .clk     (clk),
            .rst     (rst),
            .src_pad (src_pad),
            .cfg     (cfg[c]),
            .trig    (trig[c]),
            .resel   (resel[c]),
            .hit     (set_vec[c])
        );
        assign en_vec[c] = cfg[c].en;
    end

    assign trig_vec = trig;
    assign irq_req  = status;

endmodule

// File: rtl/mapper_checker.sv
module mapper_checker
    import mapper_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_wr,
    input logic [CH_COUNT-1:0]        irq_req,
    input logic [CH_COUNT-1:0]        en_vec,
    input logic [CH_COUNT*TRIG_W-1:0] trig_vec
);

    localparam int HALF = CH_COUNT * TRIG_W / 2;

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always @(negedge clk) begin
        if (rst_q === 1'b1) begin
            AST_RESET_CLEARS: assert (irq_req == '0) else $error("request active in reset"); // R1
        end
    end

    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (rst)
        ((irq_req & ~$past(irq_req) & ~$past(en_vec)) == '0))
        else $error("disabled channel raised request"); // R8

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|($past(irq_req) & ~irq_req)) |-> $past(bus_wr && (bus_addr == ADDR_STATUS)))
        else $error("request dropped without status write"); // R6

    AST_TRIG_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && (bus_addr == ADDR_TRIG_LO)) |-> $stable(trig_vec[2*HALF-1:HALF]))
        else $error("low trigger write touched upper half"); // R3

    AST_TRIG_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && (bus_addr == ADDR_TRIG_HI)) |-> $stable(trig_vec[HALF-1:0]))
        else $error("high trigger write touched lower half"); // R3

endmodule

bind gpio_irq_mapper mapper_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .irq_req  (irq_req),
    .en_vec   (en_vec),
    .trig_vec (trig_vec)
);

// File: tb/gpio_irq_mapper_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_mapper_tb_top;

    localparam int NSRC = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NSRC-1:0] gpio = '0;
    logic [31:0] irq_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    gpio_irq_mapper #(.NUM_SRC(NSRC)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gpio_src(gpio), .irq_req(irq_req)
    );

    // Behavioural reference state
    logic [7:0]  m_cfg   [32];
    logic [1:0]  m_trig  [32];
    bit          m_s1    [32];
    bit          m_s2    [32];
    bit          m_prev  [32];
    int          m_blank [32];
    logic [31:0] m_status;

    always @(posedge clk) begin
        logic [31:0] nset;
        bit hitv;
        int idx;
        if (rst) begin
            for (int c = 0; c < 32; c++) begin
                m_cfg[c] = '0; m_trig[c] = '0; m_s1[c] = 0; m_s2[c] = 0;
                m_prev[c] = 0; m_blank[c] = 0;
            end
            m_status = '0;
        end else begin
            nset = '0;
            for (int c = 0; c < 32; c++) begin
                case (m_trig[c])
                    2'd0: hitv = m_s2[c] && !m_prev[c];
                    2'd1: hitv = !m_s2[c] && m_prev[c];
                    2'd2: hitv = m_s2[c];
                    default: hitv = !m_s2[c];
                endcase
                if (m_cfg[c][7] && m_blank[c] == 0 && hitv) nset[c] = 1'b1;
            end
            for (int c = 0; c < 32; c++) begin
                m_prev[c] = m_s2[c];
                m_s2[c] = m_s1[c];
                idx = int'(m_cfg[c][6:0]);
                m_s1[c] = (idx < NSRC) ? gpio[idx] : 1'b0;
                if (m_blank[c] > 0) m_blank[c] = m_blank[c] - 1;
            end
            if (bus_wr && bus_addr == 8'h20) m_status = m_status & bus_wdata;
            m_status = m_status | nset;
            if (bus_wr) begin
                if (bus_addr == 8'h24 || bus_addr == 8'h28) begin
                    for (int k = 0; k < 16; k++)
                        m_trig[k + ((bus_addr == 8'h28) ? 16 : 0)] = bus_wdata[2*k +: 2];
                end
                if (bus_addr >= 8'h30 && bus_addr <= 8'h4C && bus_addr[1:0] == 2'b00) begin
                    for (int b = 0; b < 4; b++) begin
                        idx = int'(bus_addr - 8'h30) + b;
                        if (bus_wdata[8*b +: 7] != m_cfg[idx][6:0]) m_blank[idx] = 3;
                        m_cfg[idx] = bus_wdata[8*b +: 8];
                    end
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison of the request vector
    always @(negedge clk) begin
        if (!rst && !done) check("R6 irq_req vs reference", irq_req, m_status);
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        // R1: reset values
        check("R1 irq_req after reset", irq_req, 32'h0);
        rd_check("R1 status reset", 8'h20, 32'h0);
        rd_check("R1 trig lo reset", 8'h24, 32'h0);
        rd_check("R1 trig hi reset", 8'h28, 32'h0);
        for (int w = 0; w < 8; w++) rd_check("R1 select reset", 8'(8'h30 + 4*w), 32'h0);

        // R2/R3: configuration and layout
        wr(8'h28, 32'h0000_0008);           // ch17 high level
        wr(8'h24, 32'h0000_00E4);           // ch0 rise, ch1 fall, ch2 high, ch3 low
        rd_check("R3 trig hi unchanged by lo write", 8'h28, 32'h0000_0008);
        rd_check("R3 trig lo readback", 8'h24, 32'h0000_00E4);
        wr(8'h30, 32'hE403_8483);           // ch0 src3 en, ch1 src4 en, ch2 src3 off, ch3 src100 en
        wr(8'h40, 32'h0000_8A00);           // ch17 src10 en
        rd_check("R2 select word 0 readback", 8'h30, 32'hE403_8483);
        rd_check("R2 select word 4 readback", 8'h40, 32'h0000_8A00);
        idle(6);
        // R9: out-of-range line is constant 0, low level fires
        check("R9 low level on unimplemented line", irq_req, 32'h0000_0008);

        // R4: rising edge latency, R8: disabled ch2 on same line
        @(negedge clk); gpio[3] = 1'b1;
        @(negedge clk);
        @(negedge clk); check("R4 rising not before third edge", irq_req & 32'h1, 32'h0);
        @(negedge clk); check("R4 rising on third edge", irq_req & 32'h1, 32'h1);
        idle(4);
        check("R8 disabled channel stays quiet", irq_req & 32'h4, 32'h0);
        rd_check("R8 status with disabled channel", 8'h20, 32'h0000_0009);

        // R6/R7: clear and write-one
        wr(8'h20, ~32'h1);
        rd_check("R6 cleared bit reads 0", 8'h20, 32'h0000_0008);
        wr(8'h20, 32'hFFFF_FFFF);
        rd_check("R6 writing ones sets nothing", 8'h20, 32'h0000_0008);
        wr(8'h20, 32'h0);
        rd_check("R7 level set wins over clear", 8'h20, 32'h0000_0008);

        // R4: falling edge channel ignores rise, catches fall
        @(negedge clk); gpio[4] = 1'b1;
        idle(5);
        check("R4 falling mode ignores rise", irq_req, 32'h0000_0008);
        @(negedge clk); gpio[4] = 1'b0;
        idle(5);
        check("R4 falling mode catches fall", irq_req, 32'h0000_000A);

        // R5: high level on ch17
        @(negedge clk); gpio[10] = 1'b1;
        idle(5);
        wr(8'h20, 32'h0);
        rd_check("R5 level high held through clear", 8'h20, 32'h0002_0008);
        @(negedge clk); gpio[10] = 1'b0;
        idle(5);
        wr(8'h20, 32'h0);
        rd_check("R5 level gone then cleared", 8'h20, 32'h0000_0008);

        // R10: switching lines makes no false edge
        @(negedge clk); gpio[5] = 1'b1; gpio[6] = 1'b0;
        wr(8'h24, 32'h0000_00E5);           // ch0 falling
        wr(8'h30, 32'hE403_8485);           // ch0 -> line 5 (high, same as line 3)
        idle(6);
        wr(8'h20, 32'h0);
        rd_check("R10 status before reselect", 8'h20, 32'h0000_0008);
        wr(8'h30, 32'hE403_8486);           // ch0 -> line 6 (low)
        idle(8);
        rd_check("R10 no event from line switch", 8'h20, 32'h0000_0008);
        @(negedge clk); gpio[6] = 1'b1;
        idle(5);
        @(negedge clk); gpio[6] = 1'b0;
        idle(5);
        check("R10 detection resumes on new line", irq_req, 32'h0000_0009);

        // R11: unmapped addresses
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        rd_check("R11 unmapped 0x00 reads 0", 8'h00, 32'h0);
        rd_check("R11 unmapped 0x2C reads 0", 8'h2C, 32'h0);
        rd_check("R11 unmapped 0x50 reads 0", 8'h50, 32'h0);
        rd_check("R11 trig lo untouched", 8'h24, 32'h0000_00E5);
        rd_check("R11 select word 0 untouched", 8'h30, 32'hE403_8486);
        rd_check("R11 status untouched", 8'h20, 32'h0000_0009);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule